// File: doc/BRIEF.md
# Table-Driven Bus Master Sequencer

This block is a minimal bus master for a shared parallel bus. It runs a fixed program of bus transactions held in an internal 16-entry table. A program counter selects the current entry. Each entry supplies a 4-bit operation code, an 8-bit target address and an 8-bit write value. For every entry the block first asks an external arbiter for the bus and waits for a grant. It then presents the address and operation code, and then adds the write value. It holds all of these until the addressed slave acknowledges. After the acknowledge it releases the bus and moves on to the next entry, wrapping back to the first entry after the last.

The block never samples the data lines. It only drives them through a tri-state driver, and only while it owns the bus and is in the data phase.

An interrupt request is serviced only between transactions. The block answers it with a one-clock acknowledge pulse before it asks for the bus again. If no acknowledge ever comes from the slave, the block keeps the bus indefinitely.

Top module: `bus_seq_master`

## Requirements
- R1: While `rstN` is low, the block is idle: `busReq` = 0, `irqAck` = 0, `busCtrl` = 0, `busAddr` = 0, `busData` is released, and the program counter is 0.
- R2: One clock after reset is released, and one clock after each completed transaction, the block passes through a single idle clock with `busReq` = 0. It then raises `busReq` and holds it high while waiting for `busGrant`.
- R3: A grant sampled at a rising edge while requesting starts the address phase on that edge. In the address phase `busAddr` and `busCtrl` carry the current entry, `busData` stays released and `busReq` stays high. The data phase follows on the next edge.
- R4: `busData` is driven only during the data phase, with the entry's write value. In every other state it is high impedance and an external driver sets its level.
- R5: During the data phase `busAddr`, `busCtrl` and `busData` stay constant until `ack` is sampled high. An `ack` in the address phase, the idle clock or while waiting for grant is ignored.
- R6: `ack` sampled high in the data phase ends the transaction. On the next clock `busReq` is 0 and the block is idle. The program counter advances by one, from 15 back to 0.
- R7: `irqReq` is sampled only in the idle clock. If it is high there, the next clock asserts `irqAck` for exactly one cycle with `busReq` = 0, and arbitration follows. At any other time `irqReq` is ignored.
- R8: Table entry k (0..15) holds operation code ((5k+3) mod 15)+1, address (17k+32) mod 256, and write value ((29k) mod 256) XOR 0xA5.
- R9: When the block does not own the bus, `busCtrl` and `busAddr` are parked at 0. No table entry uses operation code 0, so 0 always means "no operation".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busGrant | input | 1 | Bus grant from the arbiter |
| ack | input | 1 | Slave completion of the current transaction |
| irqReq | input | 1 | Interrupt request |
| busReq | output | 1 | Bus request to the arbiter |
| irqAck | output | 1 | Interrupt acknowledge pulse |
| busCtrl | output | 4 | Operation code of the current transaction, 0 when idle |
| busAddr | output | 8 | Target address, 0 when idle |
| busData | inout | 8 | Write data, tri-stated outside the data phase |

## Verification
The bench goes after acknowledges that arrive in the address phase or while waiting for grant. A design that takes them would skip table entries or cut the data phase short. The bench watches interrupts raised during a transaction, which a wrong design acknowledges mid-cycle with the bus still held. It also watches for an acknowledge pulse that lasts more than one clock. It checks the data lines while an external driver holds them outside the data phase, which exposes a driver left enabled. It runs well past sixteen transactions to catch a counter that fails to wrap, and resets in the middle of a run to catch state that survives reset.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INTA = 3'd1,
    ST_ARB  = 3'd2,
    ST_ADDR = 3'd3,
    ST_DATA = 3'd4
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic driveAddr;
    logic driveData;
    logic pcAdvance;
  } dpStrobe_t;

  // Operation code of entry k; never zero
  function automatic int unsigned progCtrl(input int unsigned k, input int unsigned ctrlW);
    int unsigned span;
    span = (32'd1 << ctrlW) - 32'd1;
    return ((5 * k + 3) % span) + 1;
  endfunction

  function automatic int unsigned progAddr(input int unsigned k, input int unsigned addrW);
    return (17 * k + 32) % (32'd1 << addrW);
  endfunction

  function automatic int unsigned progData(input int unsigned k, input int unsigned dataW);
    int unsigned mask;
    mask = (32'd1 << dataW) - 32'd1;
    return ((29 * k) & mask) ^ (32'hA5 & mask);
  endfunction

endpackage

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
  import bsm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busGrant,
  input  logic       ack,
  input  logic       irqReq,
  output logic       busReq,
  output logic       irqAck,
  output dpStrobe_t  strobe
);

  seqState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // Phase sequencing: idle -> (irq ack) -> arbitration -> address -> data
  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: stateD = irqReq ? ST_INTA : ST_ARB;
      ST_INTA: stateD = ST_ARB;
      ST_ARB:  if (busGrant) stateD = ST_ADDR;
      ST_ADDR: stateD = ST_DATA;
      ST_DATA: if (ack) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    busReq           = (stateQ == ST_ARB) || (stateQ == ST_ADDR) || (stateQ == ST_DATA);
    irqAck           = (stateQ == ST_INTA);
    strobe.driveAddr = (stateQ == ST_ADDR) || (stateQ == ST_DATA);
    strobe.driveData = (stateQ == ST_DATA);
    strobe.pcAdvance = (stateQ == ST_DATA) && ack;
  end

endmodule

// File: rtl/bsm_datapath.sv
module bsm_datapath
  import bsm_pkg::*;
#(
  parameter int CTRL_W     = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PROG_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic [CTRL_W-1:0] busCtrl,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int PC_W = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(PROG_DEPTH - 1);

  logic [PC_W-1:0]   pcQ;
  logic [CTRL_W-1:0] romCtrl [PROG_DEPTH];
  logic [ADDR_W-1:0] romAddr [PROG_DEPTH];
  logic [DATA_W-1:0] romData [PROG_DEPTH];

  // Program table, computed per entry
  for (genvar g = 0; g < PROG_DEPTH; g++) begin : g_rom
    assign romCtrl[g] = CTRL_W'(progCtrl(g, CTRL_W));
    assign romAddr[g] = ADDR_W'(progAddr(g, ADDR_W));
    assign romData[g] = DATA_W'(progData(g, DATA_W));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pcQ <= '0;
    else if (strobe.pcAdvance) pcQ <= (pcQ == PC_LAST) ? '0 : pcQ + 1'b1;
  end

  always_comb begin
    busCtrl = strobe.driveAddr ? romCtrl[pcQ] : '0;
    busAddr = strobe.driveAddr ? romAddr[pcQ] : '0;
    dataOut = romData[pcQ];
    dataOe  = strobe.driveData;
  end

endmodule

// File: rtl/bus_seq_master.sv
module bus_seq_master
  import bsm_pkg::*;
#(
  parameter int CTRL_W     = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PROG_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busGrant,
  input  logic              ack,
  input  logic              irqReq,
  output logic              busReq,
  output logic              irqAck,
  output logic [CTRL_W-1:0] busCtrl,
  output logic [ADDR_W-1:0] busAddr,
  inout  wire  [DATA_W-1:0] busData
);

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] dataOut;
  logic              dataOe;
  logic              dataOwn;

  bsm_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busGrant (busGrant),
    .ack      (ack),
    .irqReq   (irqReq),
    .busReq   (busReq),
    .irqAck   (irqAck),
    .strobe   (strobe)
  );

  bsm_datapath #(
    .CTRL_W     (CTRL_W),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PROG_DEPTH (PROG_DEPTH)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busCtrl (busCtrl),
    .busAddr (busAddr),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

  assign dataOwn = strobe.driveData;
  assign busData = dataOe ? dataOut : {DATA_W{1'bz}};

endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
  parameter int CTRL_W = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busGrant,
  input logic              ack,
  input logic              busReq,
  input logic              irqAck,
  input logic [CTRL_W-1:0] busCtrl,
  input logic [ADDR_W-1:0] busAddr,
  input logic              dataOwn
);

  // R9: a nonzero operation code is only shown while requesting
  a_r9_own_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    (busCtrl != '0) |-> busReq);

  // R3: bus ownership begins only after a sampled grant
  a_r3_own_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busCtrl != '0) |-> $past(busGrant) && $past(busReq));

  // R5: address and code hold while no acknowledge is seen
  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    ((busCtrl != '0) && !ack) |=> (busCtrl == $past(busCtrl)) && (busAddr == $past(busAddr)));

  // R6: acknowledge in data phase drops the request next clock
  a_r6_req_drop: assert property (@(posedge clk) disable iff (!rstN)
    (dataOwn && ack) |=> !busReq && (busCtrl == '0));

  // R7: interrupt acknowledge is a single clock pulse without request
  a_r7_inta_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !irqAck && busReq);

  a_r7_inta_no_req: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |-> !busReq && (busCtrl == '0));

  // R4: data phase only while the code is presented
  a_r4_data_in_own: assert property (@(posedge clk) disable iff (!rstN)
    dataOwn |-> (busCtrl != '0) && busReq);

endmodule

bind bus_seq_master bsm_checker #(
  .CTRL_W (CTRL_W),
  .ADDR_W (ADDR_W)
) i_bsm_checker (
  .clk      (clk),
  .rstN     (rstN),
  .busGrant (busGrant),
  .ack      (ack),
  .busReq   (busReq),
  .irqAck   (irqAck),
  .busCtrl  (busCtrl),
  .busAddr  (busAddr),
  .dataOwn  (dataOwn)
);

// File: tb/test_bus_seq_master.sv
`timescale 1ns/1ps
module test_bus_seq_master;

  localparam int RUN_CYCLES = 3000;
  localparam int RESET_AT   = 1500;

  localparam int M_IDLE = 0, M_INTA = 1, M_ARB = 2, M_ADDR = 3, M_DATA = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       busGrant, ack, irqReq;
  logic       busReq, irqAck;
  logic [3:0] busCtrl;
  logic [7:0] busAddr;
  wire  [7:0] busData;
  logic       tbDrv;
  logic [7:0] tbVal;

  int checks = 0;
  int errors = 0;
  int mState, mPc, wraps, done;

  always #2.5 clk = ~clk;

  assign busData = tbDrv ? tbVal : 8'bz;

  bus_seq_master i_bus_seq_master (
    .clk      (clk),
    .rstN     (rstN),
    .busGrant (busGrant),
    .ack      (ack),
    .irqReq   (irqReq),
    .busReq   (busReq),
    .irqAck   (irqAck),
    .busCtrl  (busCtrl),
    .busAddr  (busAddr),
    .busData  (busData)
  );

  // Table contents as the requirement gives them (R8)
  function automatic int expCode(input int k);
    return ((5 * k + 3) % 15) + 1;
  endfunction
  function automatic int expAddr(input int k);
    return (17 * k + 32) % 256;
  endfunction
  function automatic int expWdata(input int k);
    return ((29 * k) % 256) ^ 'hA5;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic checkAll(input logic inReset);
    bit own;
    own = (mState == M_ADDR) || (mState == M_DATA);
    if (inReset) begin
      chk("R1 busReq", int'(busReq), 0);
      chk("R1 irqAck", int'(irqAck), 0);
      chk("R1 busCtrl", int'(busCtrl), 0);
      chk("R1 busAddr", int'(busAddr), 0);
      chk("R1 busData released", int'(busData), int'(tbVal));
    end else begin
      chk(mState == M_ARB ? "R2 busReq" : (mState == M_IDLE ? "R6 busReq" : "R3 busReq"),
          int'(busReq), int'(mState == M_ARB || own));
      chk("R7 irqAck", int'(irqAck), int'(mState == M_INTA));
      chk(mState == M_DATA ? "R5 busCtrl" : (own ? "R3 busCtrl" : "R9 busCtrl"),
          int'(busCtrl), own ? expCode(mPc) : 0);
      chk(own ? "R8 busAddr" : "R9 busAddr", int'(busAddr), own ? expAddr(mPc) : 0);
      chk(mState == M_DATA ? "R8 busData" : "R4 busData", int'(busData),
          mState == M_DATA ? expWdata(mPc) : int'(tbVal));
    end
  endtask

  task automatic driveAndStep();
    busGrant = (mState == M_ADDR || mState == M_DATA) ? 1'b1 : (($urandom % 3) == 0);
    ack      = ($urandom % 4) == 0;
    irqReq   = ($urandom % 5) == 0;
    case (mState)
      M_IDLE: mState = irqReq ? M_INTA : M_ARB;
      M_INTA: mState = M_ARB;
      M_ARB:  if (busGrant) mState = M_ADDR;
      M_ADDR: mState = M_DATA;
      M_DATA: if (ack) begin
        mState = M_IDLE;
        if (mPc == 15) wraps++;
        mPc = (mPc + 1) % 16;
      end
      default: mState = M_IDLE;
    endcase
    tbDrv = (mState != M_DATA);
    tbVal = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    done = 0; wraps = 0; mState = M_IDLE; mPc = 0;
    rstN = 1'b0; busGrant = 1'b0; ack = 1'b0; irqReq = 1'b0;
    tbDrv = 1'b1; tbVal = 8'h5A;
    repeat (3) @(negedge clk);
    // R1 with grant, ack and irq all high during reset
    busGrant = 1'b1; ack = 1'b1; irqReq = 1'b1;
    @(negedge clk);
    checkAll(1'b1);
    rstN = 1'b1;
    driveAndStep();
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk);
      if (cyc == RESET_AT) begin
        rstN = 1'b0;
        mState = M_IDLE; mPc = 0;
        #0.1;
        checkAll(1'b1);
      end else if (cyc == RESET_AT + 1) begin
        checkAll(1'b1);
        rstN = 1'b1;
        driveAndStep();
      end else begin
        checkAll(1'b0);
        driveAndStep();
      end
    end
    chk("R6 program wrapped", int'(wraps > 0), 1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * (RUN_CYCLES + 200));
    if (done == 0) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule